// File: doc/BRIEF.md
# STN Pixel Word Unpacker

This block turns 32-bit frame-buffer words into a stream of single pixels for a passive-matrix (STN) panel. One word holds 32, 16, 8, 4 or 2 pixels, depending on the selected depth of 1, 2, 4, 8 or 16 bits per pixel. The unpacker emits those pixels one at a time, in order. A swap control selects between two placements of pixels within the word. With swap clear the packing is plain little-endian. With swap set, every byte is read from its most significant end, and bytes are still taken from the lowest address upward. At 8 and 16 bpp the pixel value is also split into red, green and blue fields for colour STN panels.

Words arrive on a valid/ready interface. The depth code and swap bit travel beside the word and are captured together with it. Pixels leave on a second valid/ready interface. Back-pressure rules are as follows. The output holds its pixel and all its fields while `px_valid` is high and `px_ready` is low. A word is taken (`in_valid && in_ready`) only when the unpacker is empty, or in the same cycle that the last pixel of the current word is taken downstream. This gives gap-free streaming between words. `in_ready` therefore depends combinationally on `px_ready`.

Top module: `stn_word_unpacker`

## Requirements
- R1: After reset, `px_valid` is low and `in_ready` is high.
- R2: With swap clear, depth code 0/1/2/3/4 selects 1/2/4/8/16 bpp (d bits). Pixel k of the word, for k = 0 .. 32/d-1, is bits [k*d +: d]. The pixels are emitted in order of k.
- R3: With swap set at 1, 2 or 4 bpp, pixel k sits in byte k/(8/d). Within that byte, the slot s = k mod (8/d) takes bits [8 - d*(s+1) +: d], so the first pixel of each byte is at its top.
- R4: With swap set at 8 or 16 bpp, the placement equals that of R2.
- R5: At 8 bpp, red is pixel bits 7:6, green is bits 5:3 and blue is bits 2:0. Each is zero-extended to 4 bits.
- R6: At 16 bpp, red is pixel bits 11:8, green is bits 7:4 and blue is bits 3:0. Bits 15:12 do not affect the colour outputs but do appear on `px_index`.
- R7: At 1, 2 and 4 bpp, the red, green and blue outputs are zero.
- R8: `px_index` carries the pixel value zero-extended to 16 bits.
- R9: While `px_valid` is high and `px_ready` is low, `px_valid` stays high and all pixel outputs stay unchanged in the next cycle.
- R10: `in_ready` is high exactly when no pixel is pending, or when the last pixel of the current word is pending and `px_ready` is high. When a word is taken on such a handoff, its first pixel is valid in the next cycle.
- R11: `cfg_depth` and `cfg_swap` are sampled only when a word is taken. Changes at other times do not affect the pixels of the current word.
- R12: Depth codes 5, 6 and 7 behave as code 4 (16 bpp).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_word | input | 32 | Frame-buffer word |
| cfg_depth | input | 3 | Depth code (0..4 = 1,2,4,8,16 bpp; 5..7 as 4) |
| cfg_swap | input | 1 | Set: top-of-byte-first placement below 8 bpp |
| px_valid | output | 1 | Pixel valid |
| px_ready | input | 1 | Downstream takes the pixel |
| px_index | output | 16 | Raw pixel value, zero-extended |
| px_red | output | 4 | Red field |
| px_green | output | 4 | Green field |
| px_blue | output | 4 | Blue field |

## Verification
The bench builds the unpacker with its default parameters: a 32-bit word, a 16-bit pixel index and 4-bit colour channels. With these values every depth code, including the three folded codes, and both placements can be reached on directed and random words. A behavioural model predicts every pixel from the stated bit formulas. The bench throttles both interfaces at random, which exercises stalls and same-cycle word handoffs. It also scrambles the configuration while a word is in flight.

// File: rtl/stn_unpack_pkg.sv
package stn_unpack_pkg;
  localparam int WORD_W_DEF = 32;
  localparam int PIX_W_DEF  = 16;
  localparam int CH_W_DEF   = 4;
  localparam int LG_W       = 3;

  // log2 of the depth in bits; codes above 16 bpp fold onto 16 bpp
  typedef enum logic [LG_W-1:0] {
    LG_1BPP  = 3'd0,
    LG_2BPP  = 3'd1,
    LG_4BPP  = 3'd2,
    LG_8BPP  = 3'd3,
    LG_16BPP = 3'd4
  } depth_lg_e;

  function automatic logic [LG_W-1:0] fold_depth(input logic [LG_W-1:0] code);
    return (code > LG_16BPP) ? LG_16BPP : code;
  endfunction
endpackage

// File: rtl/stn_slot_locator.sv
module stn_slot_locator #(
  parameter int WORD_W = 32
) (
  input  logic [2:0]                  lg,
  input  logic                        swap,
  input  logic [$clog2(WORD_W)-1:0]   slot,
  output logic [$clog2(WORD_W)-1:0]   lsb,
  output logic [$clog2(WORD_W)-1:0]   last_slot
);
  localparam int SLOT_W = $clog2(WORD_W);

  logic [SLOT_W-1:0] flip;
  logic [SLOT_W-1:0] pos;

  // below 8 bpp with swap set, slot order inside each byte is mirrored
  always_comb begin
    flip = '0;
    if (swap) begin
      case (lg)
        3'd0:    flip = SLOT_W'(7);
        3'd1:    flip = SLOT_W'(3);
        3'd2:    flip = SLOT_W'(1);
        default: flip = '0;
      endcase
    end
    pos       = slot ^ flip;
    lsb       = pos << lg;
    last_slot = SLOT_W'((WORD_W >> lg) - 1);
  end
endmodule

// File: rtl/stn_field_picker.sv
module stn_field_picker #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 16
) (
  input  logic [WORD_W-1:0]         word,
  input  logic [$clog2(WORD_W)-1:0] lsb,
  input  logic [2:0]                lg,
  output logic [PIX_W-1:0]          pix
);
  logic [WORD_W-1:0] shifted;
  logic [PIX_W-1:0]  mask;

  always_comb begin
    shifted = word >> lsb;
    for (int i = 0; i < PIX_W; i++) begin
      mask[i] = (i < (1 << lg));
    end
    pix = shifted[PIX_W-1:0] & mask;
  end
endmodule

// File: rtl/stn_color_split.sv
module stn_color_split #(
  parameter int PIX_W = 16,
  parameter int CH_W  = 4
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [2:0]       lg,
  output logic [CH_W-1:0]  red,
  output logic [CH_W-1:0]  green,
  output logic [CH_W-1:0]  blue
);
  always_comb begin
    red   = '0;
    green = '0;
    blue  = '0;
    case (lg)
      3'd3: begin
        red   = CH_W'(pix[7:6]);
        green = CH_W'(pix[5:3]);
        blue  = CH_W'(pix[2:0]);
      end
      3'd4: begin
        red   = CH_W'(pix[11:8]);
        green = CH_W'(pix[7:4]);
        blue  = CH_W'(pix[3:0]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stn_word_unpacker.sv
module stn_word_unpacker
  import stn_unpack_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int PIX_W  = PIX_W_DEF,
  parameter int CH_W   = CH_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_swap,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [PIX_W-1:0]  px_index,
  output logic [CH_W-1:0]   px_red,
  output logic [CH_W-1:0]   px_green,
  output logic [CH_W-1:0]   px_blue
);
  localparam int SLOT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word_q;
  logic [2:0]        lg_q;
  logic              swap_q;
  logic [SLOT_W-1:0] slot_q;
  logic              busy_q;

  logic [SLOT_W-1:0] lsb;
  logic [SLOT_W-1:0] last_slot;
  logic              at_last;
  logic              in_fire;
  logic              out_fire;

  stn_slot_locator #(.WORD_W(WORD_W)) u_loc (
    .lg        (lg_q),
    .swap      (swap_q),
    .slot      (slot_q),
    .lsb       (lsb),
    .last_slot (last_slot)
  );

  stn_field_picker #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_pick (
    .word (word_q),
    .lsb  (lsb),
    .lg   (lg_q),
    .pix  (px_index)
  );

  stn_color_split #(.PIX_W(PIX_W), .CH_W(CH_W)) u_col (
    .pix   (px_index),
    .lg    (lg_q),
    .red   (px_red),
    .green (px_green),
    .blue  (px_blue)
  );

  assign at_last  = (slot_q == last_slot);
  assign px_valid = busy_q;
  assign out_fire = busy_q && px_ready;
  assign in_ready = !busy_q || (px_ready && at_last);
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lg_q   <= '0;
      swap_q <= 1'b0;
      slot_q <= '0;
      busy_q <= 1'b0;
    end else if (in_fire) begin
      word_q <= in_word;
      lg_q   <= fold_depth(cfg_depth);
      swap_q <= cfg_swap;
      slot_q <= '0;
      busy_q <= 1'b1;
    end else if (out_fire) begin
      if (at_last) begin
        busy_q <= 1'b0;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  // R9: stalled pixel holds
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready |=> px_valid && $stable(px_index) && $stable(px_red)
                               && $stable(px_green) && $stable(px_blue));

  // R10: a word taken while a pixel is pending only on the final handoff
  a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && px_valid |-> px_ready);

  // R10: accepted word gives a valid pixel next cycle
  a_r10_next_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> px_valid);

  // R7: low depths carry no colour
  a_r7_dark_low: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && lg_q < 3'd3 |-> px_red == '0 && px_green == '0 && px_blue == '0);

  // R5: red is only two bits wide at 8 bpp
  a_r5_red_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && lg_q == 3'd3 |-> px_red[CH_W-1:2] == '0 && px_index[PIX_W-1:8] == '0);

  // R8: 1 bpp index is a single bit
  a_r8_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && lg_q == 3'd0 |-> px_index[PIX_W-1:1] == '0);

  // R12: folded depth never exceeds 16 bpp
  a_r12_fold: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> lg_q <= 3'd4);
endmodule

// File: tb/stn_word_unpacker_tb.sv
module stn_word_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [2:0]  cfg_depth = '0;
  logic        cfg_swap = 1'b0;
  logic        px_valid;
  logic        px_ready = 1'b0;
  logic [15:0] px_index;
  logic [3:0]  px_red, px_green, px_blue;

  always #10 clk = ~clk;

  stn_word_unpacker u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .cfg_depth(cfg_depth), .cfg_swap(cfg_swap),
    .px_valid(px_valid), .px_ready(px_ready),
    .px_index(px_index), .px_red(px_red), .px_green(px_green), .px_blue(px_blue)
  );

  typedef struct packed {
    logic [15:0] idx;
    logic [3:0]  r, g, b;
    logic [4:0]  width;
    logic [2:0]  code;
    logic        swap;
    logic [3:0]  pos_req;
    logic [3:0]  col_req;
  } exp_t;

  exp_t        eq[$];
  logic [31:0] sw[$];
  logic [2:0]  sd[$];
  logic        ss[$];

  int checks = 0;
  int fails  = 0;

  function automatic string rq(input int n);
    case (n)
      2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";
      11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirement formulas
  task automatic push_word(input logic [31:0] w, input logic [2:0] code, input logic swp);
    int d, n, base, ppb;
    logic [31:0] t, m;
    exp_t e;
    d = (code > 3'd4) ? 16 : (1 << code);
    n = 32 / d;
    for (int k = 0; k < n; k++) begin
      if (!swp || d >= 8) base = k * d;
      else begin
        ppb  = 8 / d;
        base = (k / ppb) * 8 + 8 - d * ((k % ppb) + 1);
      end
      t = w >> base;
      m = (32'd1 << d) - 32'd1;
      t = t & m;
      e.idx   = t[15:0];
      e.width = 5'(d);
      e.code  = code;
      e.swap  = swp;
      e.r = '0; e.g = '0; e.b = '0;
      if (d == 8) begin
        e.r = {2'b0, t[7:6]}; e.g = {1'b0, t[5:3]}; e.b = {1'b0, t[2:0]};
        e.col_req = 4'd5;
      end else if (d == 16) begin
        e.r = t[11:8]; e.g = t[7:4]; e.b = t[3:0];
        e.col_req = 4'd6;
      end else e.col_req = 4'd7;
      if (code > 3'd4)      e.pos_req = 4'd12;
      else if (!swp)        e.pos_req = 4'd2;
      else if (d < 8)       e.pos_req = 4'd3;
      else                  e.pos_req = 4'd4;
      eq.push_back(e);
    end
  endtask

  initial begin
    logic [31:0] pats [4];
    bit holding;
    bit stall_prev;
    logic [15:0] h_idx;
    logic [3:0]  h_r, h_g, h_b;
    bit in_f, out_f, exp_rdy;
    int cyc;
    exp_t e;
    string pr;

    pats[0] = 32'h1234_5678;
    pats[1] = 32'h8000_0001;
    pats[2] = 32'hFFFF_0000;
    pats[3] = 32'hA5C3_F00F;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 4; p++) begin
          sw.push_back(pats[p]); sd.push_back(3'(c)); ss.push_back(s[0]);
        end
    for (int i = 0; i < 200; i++) begin
      sw.push_back($urandom); sd.push_back(3'($urandom % 8)); ss.push_back(1'($urandom));
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(px_valid == 1'b0, "R1", "px_valid after reset", 32'(px_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);

    holding = 0; stall_prev = 0; cyc = 0;
    forever begin
      // outputs as left by the last clock edge
      check(px_valid == (eq.size() != 0), "R10", "px_valid", 32'(px_valid), 32'(eq.size() != 0));
      if (stall_prev) begin
        check(px_valid && px_index == h_idx && px_red == h_r && px_green == h_g && px_blue == h_b,
              "R9", "stalled pixel changed", {px_index, px_red, px_green, px_blue, 3'b0, px_valid},
              {h_idx, h_r, h_g, h_b, 4'b0001});
      end

      // drive inputs for the next edge
      if (!holding) begin
        if (sw.size() > 0 && ($urandom % 4 != 0)) begin
          in_valid = 1'b1; in_word = sw[0]; cfg_depth = sd[0]; cfg_swap = ss[0];
          holding = 1;
        end else begin
          // R11: configuration churns while a word is in flight
          in_valid = 1'b0; in_word = $urandom;
          cfg_depth = 3'($urandom % 8); cfg_swap = 1'($urandom);
        end
      end
      px_ready = (cyc % 500 < 100) ? 1'b1 : ($urandom % 4 != 0);
      #1;

      exp_rdy = (eq.size() == 0) || (eq.size() == 1 && px_ready);
      check(in_ready == exp_rdy, "R10", "in_ready", 32'(in_ready), 32'(exp_rdy));
      in_f  = in_valid && in_ready;
      out_f = px_valid && px_ready;
      stall_prev = px_valid && !px_ready;
      h_idx = px_index; h_r = px_red; h_g = px_green; h_b = px_blue;

      if (out_f && eq.size() > 0) begin
        e  = eq.pop_front();
        pr = ((cfg_depth != e.code || cfg_swap != e.swap) && !in_f) ? "R11" : rq(int'(e.pos_req));
        check(px_index == e.idx, pr, "px_index", 32'(px_index), 32'(e.idx));
        check((32'(px_index) >> e.width) == 0, "R8", "index above width", 32'(px_index), 32'(e.idx));
        check({px_red, px_green, px_blue} == {e.r, e.g, e.b}, rq(int'(e.col_req)), "rgb",
              32'({px_red, px_green, px_blue}), 32'({e.r, e.g, e.b}));
      end
      if (in_f) begin
        push_word(sw[0], sd[0], ss[0]);
        void'(sw.pop_front()); void'(sd.pop_front()); void'(ss.pop_front());
        holding = 0;
      end

      cyc++;
      if (sw.size() == 0 && !holding && eq.size() == 0) break;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        break;
      end
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule